// File: doc/BRIEF.md
# Energy Dispersal Descrambler with Frame Lock

This block sits after the error-correction stage of a broadcast transport receiver. It takes a byte stream of corrected packets in which the first byte of each packet is a sync byte. Each packet arrives with a start-of-packet flag and a flag saying whether the packet could not be corrected. Packets are grouped into frames of eight. The first packet of a frame carries the inverted sync value B8h and the other seven carry 47h. The block aligns a free-running packet-in-frame counter to the first B8h sync byte found in a packet that is flagged good. From then on it removes the energy-dispersal scrambling by XORing every payload byte with a 15-bit pseudo-random sequence. Sync bytes are left as they are.

The sequence generator restarts from its seed at every frame start. It steps through the sync bytes of the other seven packets without applying them. The output carries the byte, its start-of-packet flag and a packet error flag. The error flag is held for the whole packet. It is low only when the frame lock is held and the packet arrived flagged good.

Top module: `edp_descrambler`

## Requirements
- R1: While reset is held and after it is released, with no input yet, out_valid and out_begin are 0 and out_err is 1.
- R2: Each accepted input byte (in_valid=1) appears on the outputs exactly one clock later with out_valid=1. out_begin follows in_begin. A cycle with in_valid=0 gives out_valid=0 and out_begin=0 one clock later, and it does not advance the sequence.
- R3: Until the first lock, every byte passes through unchanged and out_err is 1.
- R4: Lock is taken only when a start byte (in_begin=1) equals B8h and in_bad=0. A B8h start byte with in_bad=1 does not lock. Once taken, the lock is kept until reset.
- R5: The sequence uses the polynomial 1 + x^14 + x^15 with seed 100101010000000, loaded into stages 1 to 15. Each payload byte is XORed with the next 8 sequence bits, the first bit going to bit 7. So the first payload byte of a frame is XORed with 03h.
- R6: Sync bytes, meaning the bytes with in_begin=1, are never modified, whether they are B8h or 47h.
- R7: In packets 2 to 8 of a frame, the sequence advances 8 bits on the sync byte without applying them, so payload descrambling continues across packets.
- R8: The packet-in-frame counter advances on every start byte. It restarts the frame, reloading the seed, after 8 packets even if the start byte is not B8h. Any good B8h start byte realigns it at once.
- R9: out_err is set at the start byte to (in_bad OR not locked), where the lock includes the current start byte. It holds that value for every byte of the packet.
- R10: in_bad is ignored on bytes with in_begin=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | BYTE_W | Corrected packet byte |
| in_begin | input | 1 | First (sync) byte of a packet |
| in_bad | input | 1 | Packet uncorrectable, sampled with in_begin |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | BYTE_W | Descrambled byte |
| out_begin | output | 1 | First byte of a packet |
| out_err | output | 1 | Packet error, held for the packet |

## Verification
On every cycle the checker enforces the one-cycle latency and the valid qualifier. It also checks that sync bytes pass unchanged, that bytes pass unchanged before lock, that the error flag holds within a packet, that a bad packet raises the error flag, and that the lock stays once taken. The actual sequence values can only be shown by the bench's scenarios: the 03h mask on the first payload byte, continuity across the sync bytes, the reload at the eight-packet wrap and realignment by a mid-frame B8h. These scenarios compare every output byte against an independent model of the sequence.

// File: rtl/edp_pkg.sv
package edp_pkg;
   // stage 1 is bit 0; seed 1001010 1000 0000 over stages 1..15
   localparam logic [14:0] EDP_SEED_DEFAULT = 15'h00A9;
   localparam logic [7:0]  EDP_INV_SYNC     = 8'hB8;

   typedef struct packed {
      logic reload;    // frame start: load seed
      logic advance;   // step sequence by one byte
      logic scramble;  // apply mask to this byte
      logic blk_err;   // packet error value taken at start byte
   } edp_ctl_t;
endpackage

// File: rtl/edp_prbs_gen.sv
module edp_prbs_gen #(
   parameter int unsigned LFSR_W = 15,
   parameter int unsigned TAP_A  = 14,
   parameter int unsigned TAP_B  = 15,
   parameter int unsigned BYTE_W = 8,
   parameter logic [LFSR_W-1:0] SEED = edp_pkg::EDP_SEED_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              advance,
   output logic [BYTE_W-1:0] mask
);
   localparam int unsigned IA = TAP_A - 1;
   localparam int unsigned IB = TAP_B - 1;

   if (TAP_A == 0 || TAP_B > LFSR_W || TAP_A >= TAP_B)
      $error("edp_prbs_gen: taps must satisfy 0 < TAP_A < TAP_B <= LFSR_W");
   if (BYTE_W == 0)
      $error("edp_prbs_gen: BYTE_W must be non-zero");

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] chain [0:BYTE_W];

   assign chain[0] = state_q;

   // unrolled serial steps, first generated bit lands in the MSB
   for (genvar i = 0; i < BYTE_W; i++) begin : g_step
      logic fb;
      assign fb = chain[i][IA] ^ chain[i][IB];
      assign mask[BYTE_W-1-i] = fb;
      assign chain[i+1] = {chain[i][LFSR_W-2:0], fb};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= SEED;
      else if (reload)
         state_q <= SEED;
      else if (advance)
         state_q <= chain[BYTE_W];
   end
endmodule

// File: rtl/edp_frame_track.sv
module edp_frame_track
   import edp_pkg::*;
#(
   parameter int unsigned       FRAME_BLKS = 8,
   parameter int unsigned       BYTE_W     = 8,
   parameter logic [BYTE_W-1:0] INV_SYNC   = EDP_INV_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_begin,
   input  logic              in_bad,
   input  logic [BYTE_W-1:0] in_data,
   output logic              locked,
   output edp_ctl_t          ctl
);
   localparam int unsigned   IDX_W = (FRAME_BLKS > 1) ? $clog2(FRAME_BLKS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BLKS - 1);

   if (FRAME_BLKS < 2)
      $error("edp_frame_track: FRAME_BLKS must be at least 2");

   logic [IDX_W-1:0] blk_idx_q;
   logic             start_byte;
   logic             good_inv;
   logic             wrap;
   logic             lock_nxt;

   assign start_byte = in_valid && in_begin;
   assign good_inv   = start_byte && !in_bad && (in_data == INV_SYNC);
   assign wrap       = (blk_idx_q == LAST_IDX);
   assign lock_nxt   = locked || good_inv;

   always_comb begin
      ctl          = '0;
      ctl.reload   = start_byte && (good_inv || wrap);
      ctl.advance  = in_valid && !ctl.reload;
      ctl.scramble = in_valid && !in_begin && locked;
      ctl.blk_err  = in_bad || !lock_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_idx_q <= '0;
         locked    <= 1'b0;
      end else if (start_byte) begin
         locked <= lock_nxt;
         if (good_inv || wrap)
            blk_idx_q <= '0;
         else
            blk_idx_q <= blk_idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/edp_descrambler.sv
module edp_descrambler
   import edp_pkg::*;
#(
   parameter int unsigned       BYTE_W     = 8,
   parameter int unsigned       FRAME_BLKS = 8,
   parameter int unsigned       LFSR_W     = 15,
   parameter int unsigned       TAP_A      = 14,
   parameter int unsigned       TAP_B      = 15,
   parameter logic [LFSR_W-1:0] SEED       = EDP_SEED_DEFAULT,
   parameter logic [BYTE_W-1:0] INV_SYNC   = EDP_INV_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_begin,
   input  logic              in_bad,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_begin,
   output logic              out_err
);
   edp_ctl_t          ctl;
   logic              frame_locked;
   logic [BYTE_W-1:0] prbs_mask;
   logic [BYTE_W-1:0] applied;

   edp_frame_track #(
      .FRAME_BLKS (FRAME_BLKS),
      .BYTE_W     (BYTE_W),
      .INV_SYNC   (INV_SYNC)
   ) track_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_begin (in_begin),
      .in_bad   (in_bad),
      .in_data  (in_data),
      .locked   (frame_locked),
      .ctl      (ctl)
   );

   edp_prbs_gen #(
      .LFSR_W (LFSR_W),
      .TAP_A  (TAP_A),
      .TAP_B  (TAP_B),
      .BYTE_W (BYTE_W),
      .SEED   (SEED)
   ) prbs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (ctl.reload),
      .advance (ctl.advance),
      .mask    (prbs_mask)
   );

   assign applied = ctl.scramble ? prbs_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_begin <= 1'b0;
         out_data  <= '0;
         out_err   <= 1'b1;
      end else begin
         out_valid <= in_valid;
         out_begin <= in_valid && in_begin;
         if (in_valid)
            out_data <= in_data ^ applied;
         if (in_valid && in_begin)
            out_err <= ctl.blk_err;
      end
   end
endmodule

// File: rtl/edp_descrambler_chk.sv
module edp_descrambler_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [BYTE_W-1:0] in_data,
   input logic              in_begin,
   input logic              in_bad,
   input logic              out_valid,
   input logic [BYTE_W-1:0] out_data,
   input logic              out_begin,
   input logic              out_err,
   input logic              locked
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && (out_begin == $past(in_begin))); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_begin); // R2
   AST_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && in_valid && !in_begin) |=> (out_data == $past(in_data)) && out_err); // R3
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R4
   AST_SYNC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_begin) |=> (out_data == $past(in_data))); // R6
   AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_begin && in_bad) |=> out_err); // R9
   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_begin) |=> $stable(out_err)); // R10
endmodule

bind edp_descrambler edp_descrambler_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_begin  (in_begin),
   .in_bad    (in_bad),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_begin (out_begin),
   .out_err   (out_err),
   .locked    (frame_locked)
);

// File: tb/edp_descrambler_tb_top.sv
module edp_descrambler_tb_top;
   localparam int PKT_LEN = 188;
   localparam logic [14:0] SEED = 15'h00A9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_begin = 1'b0;
   logic       in_bad = 1'b0;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_begin;
   logic       out_err;

   int checks = 0;
   int errors = 0;

   // reference state derived from the requirements
   logic [14:0] ref_s = SEED;
   int          ref_idx = 0;
   logic        ref_locked = 1'b0;
   logic        ref_err = 1'b1;

   always #4 clk = ~clk;

   edp_descrambler dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_begin(in_begin), .in_bad(in_bad), .out_valid(out_valid),
      .out_data(out_data), .out_begin(out_begin), .out_err(out_err)
   );

   function automatic logic [7:0] mask8(input logic [14:0] s);
      logic [14:0] t = s;
      logic [7:0]  m = '0;
      for (int i = 7; i >= 0; i--) begin
         logic b;
         b = t[13] ^ t[14];
         m[i] = b;
         t = {t[13:0], b};
      end
      return m;
   endfunction

   function automatic logic [14:0] step8(input logic [14:0] s);
      logic [14:0] t = s;
      for (int i = 0; i < 8; i++) t = {t[13:0], t[13] ^ t[14]};
      return t;
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] d, input logic beg, input logic bad, input string tag);
      logic [7:0] exp_d;
      if (beg) begin
         logic good;
         good = !bad && d == 8'hB8;
         if (good || ref_idx == 7) begin ref_s = SEED; ref_idx = 0; end
         else begin ref_s = step8(ref_s); ref_idx++; end
         ref_locked = ref_locked | good;
         ref_err = bad | !ref_locked;
         exp_d = d;
      end else begin
         exp_d = ref_locked ? (d ^ mask8(ref_s)) : d;
         ref_s = step8(ref_s);
      end
      in_valid = 1'b1; in_data = d; in_begin = beg; in_bad = bad;
      @(negedge clk);
      in_valid = 1'b0; in_begin = 1'b0; in_bad = 1'b0;
      check(tag, "out_valid", 32'(out_valid), 32'd1);
      check(tag, "out_data", 32'(out_data), 32'(exp_d));
      check(tag, "out_begin", 32'(out_begin), 32'(beg));
      check(tag, "out_err", 32'(out_err), 32'(ref_err));
   endtask

   task automatic send_gap(input string tag);
      in_valid = 1'b0; in_data = 8'h5A; in_begin = 1'b1; in_bad = 1'b1;
      @(negedge clk);
      in_begin = 1'b0; in_bad = 1'b0;
      check(tag, "idle out_valid", 32'(out_valid), 32'd0);
      check(tag, "idle out_begin", 32'(out_begin), 32'd0);
   endtask

   // one packet: sync, then payload; optional idle gaps and bad pulses on payload
   task automatic send_pkt(input logic [7:0] sync, input logic bad, input bit gaps,
                           input bit bad_pulse, input string tag);
      send_byte(sync, 1'b1, bad, tag);
      for (int i = 1; i < PKT_LEN; i++) begin
         if (gaps && (i % 50 == 0)) send_gap("R2");
         send_byte(8'(i * 37 + 11), 1'b0, bad_pulse && (i % 7 == 0), tag);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
      check("R1", "out_err in reset", 32'(out_err), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
      check("R1", "out_begin after reset", 32'(out_begin), 32'd0);
      check("R1", "out_err after reset", 32'(out_err), 32'd1);
   endtask

   task automatic t_unlocked();
      send_pkt(8'h47, 1'b0, 1'b0, 1'b0, "R3");
      check("R3", "err before lock", 32'(out_err), 32'd1);
   endtask

   task automatic t_bad_inverted();
      send_pkt(8'hB8, 1'b1, 1'b0, 1'b0, "R4");
      check("R4", "bad B8 gives no lock", 32'(out_err), 32'd1);
   endtask

   task automatic t_lock_frame();
      send_byte(8'hB8, 1'b1, 1'b0, "R4");
      check("R9", "err clear after good lock", 32'(out_err), 32'd0);
      send_byte(8'h00, 1'b0, 1'b0, "R5");
      check("R5", "first payload mask", 32'(out_data), 32'h03);
      for (int i = 2; i < PKT_LEN; i++) send_byte(8'(i), 1'b0, 1'b0, "R5");
      send_pkt(8'h47, 1'b0, 1'b1, 1'b0, "R7");
      send_pkt(8'h47, 1'b1, 1'b0, 1'b0, "R9");
      send_pkt(8'h47, 1'b0, 1'b0, 1'b1, "R10");
      check("R10", "mid-packet bad ignored", 32'(out_err), 32'd0);
      for (int b = 4; b < 8; b++) send_pkt(8'h47, 1'b0, 1'b0, 1'b0, "R6");
   endtask

   task automatic t_wrap();
      send_byte(8'h47, 1'b1, 1'b0, "R8");
      send_byte(8'h00, 1'b0, 1'b0, "R8");
      check("R8", "reload at wrap", 32'(out_data), 32'h03);
      for (int i = 2; i < PKT_LEN; i++) send_byte(8'(i), 1'b0, 1'b0, "R8");
   endtask

   task automatic t_realign();
      send_pkt(8'h47, 1'b0, 1'b0, 1'b0, "R7");
      send_pkt(8'h47, 1'b0, 1'b0, 1'b0, "R7");
      send_byte(8'hB8, 1'b1, 1'b0, "R6");
      send_byte(8'h00, 1'b0, 1'b0, "R8");
      check("R8", "realign mid-frame", 32'(out_data), 32'h03);
      for (int i = 2; i < PKT_LEN; i++) send_byte(8'(i), 1'b0, 1'b0, "R8");
      send_pkt(8'h47, 1'b0, 1'b1, 1'b0, "R7");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_unlocked();
      t_bad_inverted();
      t_lock_frame();
      t_wrap();
      t_realign();
      send_gap("R2");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule